// File: doc/BRIEF.md
# Serial Receiver with Two-Word Receive Queue

This block turns an asynchronous serial line into received words. A 16x oversampling tick, made outside the block, paces a small state machine. The machine detects a start bit, confirms it at mid-bit and takes each data bit as the majority of three samples around the middle of the bit. It then checks the stop bit. The words are eight bits wide, or nine bits wide when the nine-bit mode is selected. A finished word, with its ninth bit and its framing-error flag, goes into a two-entry queue. The host empties that queue in arrival order through one read port.

A ready flag stays high while any unread word is queued. If a word completes while both entries are still unread, a sticky overrun flag is set. While that flag is set, no further words are stored, and only dropping the receive enable clears it. Dropping the port enable resets the receiver state machine and discards the queue.

Top module: `serial_rx_q2`

## Requirements
- R1: A frame is one low start bit, then 8 data bits (9 when `nine_bit_mode`=1, latched as the start bit is seen), least significant bit first, then a stop bit. Data bits 7..0 appear on `head_data` and data bit 8 on `head_bit8`. In 8-bit mode `head_bit8` reads 0.
- R2: A low level seen on a tick while idle starts a candidate start bit. The candidate is dropped, and no word is produced, if the line is high on the 9th tick (phase 8) of that bit.
- R3: Each data bit, and the stop bit, is the majority of the samples taken at phases 7, 8 and 9 of its 16-tick bit time. A wrong level at one of those phases alone does not change the result.
- R4: The queue holds two words and returns them in arrival order. A one-cycle `rd_pop` pulse removes the head word. A pop while the queue is empty has no effect. With the queue empty, `head_data`, `head_bit8` and `head_ferr` read 0.
- R5: `rx_ready` is 1 exactly while at least one unread word is queued.
- R6: `head_ferr` is 1 when the stop bit of the head word was taken as low. The flag is stored with each word and advances with it on a pop.
- R7: A word that completes while two words are unread sets `overrun_err` and is discarded. While `overrun_err` is 1, no completed word is stored.
- R8: `overrun_err` stays set through pops and is cleared only while `rx_enable` is 0.
- R9: While `port_enable` is 0, the receiver stays idle and the queue is emptied. While `port_enable` or `rx_enable` is 0, a low line starts no frame.
- R10: After reset, `rx_ready`, `overrun_err`, `head_data`, `head_bit8` and `head_ferr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_line | input | 1 | Serial input, idles high |
| port_enable | input | 1 | Serial port enable; 0 resets the receiver and empties the queue |
| rx_enable | input | 1 | Continuous receive enable; 0 blocks new frames and clears the overrun flag |
| nine_bit_mode | input | 1 | 1 selects nine data bits per frame |
| rd_pop | input | 1 | Pop the head word (one cycle per word) |
| head_data | output | 8 | Data bits 7..0 of the head word |
| head_bit8 | output | 1 | Ninth data bit of the head word |
| head_ferr | output | 1 | Framing error of the head word |
| rx_ready | output | 1 | Unread word available |
| overrun_err | output | 1 | Sticky overrun flag |

## Verification
The line passes through a two-stage synchronizer, so the state machine sees a level on the first tick more than two clocks after it changes. The bench changes the line one cycle after a tick, which lines up its own tick count with the receiver's bit phases. A word is ready two clocks after the tick at phase 9 of its stop bit: one clock for the completion pulse and one for the queue write. The bench checks the queue only after a further full idle bit. Pops, enable changes and the resulting flag and head changes all settle within one clock, and the bench samples every output at the falling edge after the event.

// File: rtl/serial_rx_q2_pkg.sv
package serial_rx_q2_pkg;
  localparam int WORD_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic              ferr;
    logic              bit8;
    logic [WORD_W-1:0] data;
  } rx_word_t;
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int STAGES  = 2,
  parameter bit IDLE_LV = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{IDLE_LV}};
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/serial_rx_deser.sv
module serial_rx_deser
  import serial_rx_q2_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     en,
  input  logic     tick,
  input  logic     rxs,
  input  logic     nine_bit_mode,
  output logic     done,
  output rx_word_t word
);
  localparam int PW   = $clog2(OSR);
  localparam int MID  = OSR / 2;
  localparam int SHW  = WORD_W + 1;
  localparam int BIW  = $clog2(SHW + 1);

  rx_state_e        st;
  logic [PW-1:0]    ph;
  logic [BIW-1:0]   bidx;
  logic [2:0]       smp;
  logic [SHW-1:0]   shreg;
  logic             nine_q;
  logic [BIW-1:0]   last_idx;

  function automatic logic maj3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction

  assign last_idx = nine_q ? BIW'(WORD_W) : BIW'(WORD_W - 1);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st     <= ST_IDLE;
      ph     <= '0;
      bidx   <= '0;
      smp    <= '0;
      done   <= 1'b0;
      nine_q <= 1'b0;
      if (rst) begin
        shreg <= '0;
        word  <= '0;
      end
    end else begin
      done <= 1'b0;
      if (tick) begin
        if (st != ST_IDLE) begin
          ph <= ph + PW'(1);
          if (ph == PW'(MID - 1)) smp[0] <= rxs;
          if (ph == PW'(MID))     smp[1] <= rxs;
          if (ph == PW'(MID + 1)) smp[2] <= rxs;
        end
        case (st)
          ST_IDLE: begin
            if (!rxs) begin
              st     <= ST_START;
              ph     <= PW'(1);
              nine_q <= nine_bit_mode;
            end
          end
          ST_START: begin
            if (ph == PW'(MID) && rxs) begin
              st <= ST_IDLE;
            end else if (ph == PW'(OSR - 1)) begin
              st   <= ST_DATA;
              bidx <= '0;
            end
          end
          ST_DATA: begin
            if (ph == PW'(OSR - 1)) begin
              shreg[bidx] <= maj3(smp);
              bidx        <= bidx + BIW'(1);
              if (bidx == last_idx) st <= ST_STOP;
            end
          end
          ST_STOP: begin
            if (ph == PW'(MID + 1)) begin
              done      <= 1'b1;
              word.data <= shreg[WORD_W-1:0];
              word.bit8 <= nine_q ? shreg[WORD_W] : 1'b0;
              word.ferr <= ~maj3({rxs, smp[1:0]});
              st        <= ST_IDLE;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  // R9: a disabled receiver returns to idle
  assert_idle_when_off_R9: assert property (@(posedge clk) disable iff (rst)
    !en |=> st == ST_IDLE);

  // R1: one completion pulse per frame
  assert_single_done_R1: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2: a high line at mid start bit abandons the frame
  assert_false_start_R2: assert property (@(posedge clk) disable iff (rst)
    (en && tick && st == ST_START && ph == PW'(MID) && rxs) |=> st == ST_IDLE);

  // R9: nothing completes while disabled
  assert_no_done_off_R9: assert property (@(posedge clk) disable iff (rst)
    !en |=> !done);
endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue
  import serial_rx_q2_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     flush,
  input  logic     clr_ovf,
  input  logic     push_req,
  input  rx_word_t wdata,
  input  logic     pop_req,
  output rx_word_t head,
  output logic     rdy,
  output logic     ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  rx_word_t        mem [DEPTH];
  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic [CW-1:0]   cnt;
  logic            full, empty, do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push_req && !ovf && !full && !flush;
  assign do_pop  = pop_req && !empty && !flush;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_ovf) ovf <= 1'b0;
    else if (push_req && full && !flush) ovf <= 1'b1;
  end

  assign head = empty ? '0 : mem[rd_ptr];
  assign rdy  = !empty;

  // R4: occupancy never exceeds the queue size
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));

  // R7: with overrun set and no pop, occupancy holds
  assert_ovf_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    (ovf && !pop_req && !flush && !clr_ovf) |=> cnt == $past(cnt));

  // R7: overrun rises only on a completion into a full queue
  assert_ovf_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> $past(push_req && full));

  // R8: overrun clears when receive is disabled
  assert_ovf_clear_R8: assert property (@(posedge clk) disable iff (rst)
    clr_ovf |=> !ovf);

  // R9: port disable empties the queue
  assert_flush_R9: assert property (@(posedge clk) disable iff (rst)
    flush |=> !rdy);

  // R5: popping the last word drops ready
  assert_ready_drop_R5: assert property (@(posedge clk) disable iff (rst)
    (pop_req && cnt == CW'(1) && !push_req) |=> !rdy);
endmodule

// File: rtl/serial_rx_q2.sv
module serial_rx_q2
  import serial_rx_q2_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DEPTH       = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              os_tick,
  input  logic              rx_line,
  input  logic              port_enable,
  input  logic              rx_enable,
  input  logic              nine_bit_mode,
  input  logic              rd_pop,
  output logic [WORD_W-1:0] head_data,
  output logic              head_bit8,
  output logic              head_ferr,
  output logic              rx_ready,
  output logic              overrun_err
);
  logic     rx_s;
  logic     frame_done;
  rx_word_t frame_word;
  rx_word_t head_word;

  serial_rx_sync #(.STAGES(SYNC_STAGES), .IDLE_LV(1'b1)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (rx_line),
    .dout (rx_s)
  );

  serial_rx_deser #(.OSR(OSR)) u_deser (
    .clk           (clk),
    .rst           (rst),
    .en            (port_enable && rx_enable),
    .tick          (os_tick),
    .rxs           (rx_s),
    .nine_bit_mode (nine_bit_mode),
    .done          (frame_done),
    .word          (frame_word)
  );

  serial_rx_queue #(.DEPTH(DEPTH)) u_queue (
    .clk      (clk),
    .rst      (rst),
    .flush    (!port_enable),
    .clr_ovf  (!rx_enable),
    .push_req (frame_done),
    .wdata    (frame_word),
    .pop_req  (rd_pop),
    .head     (head_word),
    .rdy      (rx_ready),
    .ovf      (overrun_err)
  );

  assign head_data = head_word.data;
  assign head_bit8 = head_word.bit8;
  assign head_ferr = head_word.ferr;
endmodule

// File: tb/serial_rx_q2_tb_top.sv
module serial_rx_q2_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic [1:0] div = '0;
  logic rx = 1'b1;
  logic port_en = 1'b1, rx_en = 1'b1, mode9 = 1'b0, pop = 1'b0;
  logic [7:0] h_data;
  logic h_b8, h_fe, rdy, ovf;

  int n_chk = 0, n_fail = 0;
  logic [9:0] m_q [0:1];   // {ferr, bit8..bit0}
  int m_cnt = 0;
  logic m_ovf = 1'b0;

  always #4 clk = ~clk;

  always_ff @(posedge clk) begin
    div  <= div + 2'd1;
    tick <= (div == 2'd3);
  end

  serial_rx_q2 dut_i (
    .clk(clk), .rst(rst), .os_tick(tick), .rx_line(rx),
    .port_enable(port_en), .rx_enable(rx_en), .nine_bit_mode(mode9),
    .rd_pop(pop), .head_data(h_data), .head_bit8(h_b8), .head_ferr(h_fe),
    .rx_ready(rdy), .overrun_err(ovf)
  );

  function automatic logic [9:0] exp_word(input logic [8:0] d, input logic nine, input logic stop);
    return {~stop, nine ? d[8] : 1'b0, d[7:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_tick();
    @(posedge clk);
    while (!tick) @(posedge clk);
    #1;
  endtask

  task automatic hold(input logic v, input int n);
    rx = v;
    repeat (n) wait_tick();
  endtask

  task automatic model_frame(input logic [9:0] w);
    if (port_en && rx_en && !m_ovf) begin
      if (m_cnt == 2) m_ovf = 1'b1;
      else begin m_q[m_cnt] = w; m_cnt++; end
    end
  endtask

  // glitch=1 inverts phase 8 of every data bit
  task automatic send(input logic [8:0] d, input logic stop, input logic glitch);
    int nb;
    nb = mode9 ? 9 : 8;
    hold(1'b0, 16);
    for (int i = 0; i < nb; i++) begin
      if (glitch) begin
        hold(d[i], 8); hold(~d[i], 1); hold(d[i], 7);
      end else hold(d[i], 16);
    end
    hold(stop, 16);
    model_frame(exp_word(d, mode9, stop));
    hold(1'b1, 16);
  endtask

  task automatic check_head(input string req);
    logic [9:0] e;
    @(negedge clk);
    e = (m_cnt > 0) ? m_q[0] : 10'd0;
    check({req, " data"}, 32'(h_data), 32'(e[7:0]));
    check({req, " bit8"}, 32'(h_b8), 32'(e[8]));
    check({req, " ferr"}, 32'(h_fe), 32'(e[9]));
    check("R5 ready", 32'(rdy), 32'(m_cnt > 0));
    check("R7 overrun", 32'(ovf), 32'(m_ovf));
  endtask

  task automatic do_pop(input string req);
    check_head(req);
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    if (m_cnt > 0) begin m_q[0] = m_q[1]; m_cnt--; end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [8:0] rd;
    void'($urandom(32'd4242));
    repeat (6) @(posedge clk);
    #1 rst = 1'b0;
    check_head("R10 reset");
    wait_tick();
    hold(1'b1, 16);

    // R1 8-bit frame, R5 ready, R4 pop and empty pop
    send(9'h0A5, 1'b1, 1'b0);
    do_pop("R1 8-bit");
    check_head("R5 after pop");
    do_pop("R4 empty pop");
    check_head("R4 empty");

    // R1 nine-bit mode
    mode9 = 1'b1;
    send(9'h13C, 1'b1, 1'b0);
    do_pop("R1 9-bit set");
    send(9'h0C3, 1'b1, 1'b0);
    do_pop("R1 9-bit clear");
    mode9 = 1'b0;
    send(9'h1F0, 1'b1, 1'b0);
    do_pop("R1 8-bit bit8 zero");

    // R6 framing error kept per word
    send(9'h05A, 1'b0, 1'b0);
    send(9'h066, 1'b1, 1'b0);
    do_pop("R6 ferr head");
    do_pop("R6 ferr advance");

    // R2 false start
    hold(1'b0, 6);
    hold(1'b1, 32);
    check_head("R2 false start");

    // R3 majority vote against one-sample glitches
    send(9'h096, 1'b1, 1'b1);
    do_pop("R3 glitch");
    mode9 = 1'b1;
    send(9'h169, 1'b1, 1'b1);
    do_pop("R3 glitch 9-bit");
    mode9 = 1'b0;

    // R7 overrun and blocking, R8 sticky until receive disable
    send(9'h011, 1'b1, 1'b0);
    send(9'h022, 1'b1, 1'b0);
    send(9'h033, 1'b1, 1'b0);
    check_head("R7 overrun set");
    do_pop("R7 first kept");
    send(9'h044, 1'b1, 1'b0);
    do_pop("R7 blocked store");
    check_head("R8 sticky after pops");
    @(negedge clk) rx_en = 1'b0;
    m_ovf = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 cleared", 32'(ovf), 32'd0);
    rx_en = 1'b1;
    send(9'h055, 1'b1, 1'b0);
    do_pop("R8 receive resumes");

    // R9 port disable flushes and blocks; receive disable blocks
    send(9'h077, 1'b1, 1'b0);
    check_head("R9 before flush");
    @(negedge clk) port_en = 1'b0;
    m_cnt = 0;
    repeat (2) @(negedge clk);
    check("R9 flushed", 32'(rdy), 32'd0);
    wait_tick();
    send(9'h0AA, 1'b1, 1'b0);
    check_head("R9 port disabled");
    port_en = 1'b1;
    rx_en = 1'b0;
    send(9'h0AA, 1'b1, 1'b0);
    check_head("R9 receive disabled");
    rx_en = 1'b1;

    // random mix of frames and pops
    for (int k = 0; k < 60; k++) begin
      rd = 9'($urandom);
      mode9 = 1'($urandom);
      send(rd, ($urandom % 8) != 0, 1'($urandom));
      for (int j = 0; j < int'($urandom % 3); j++) do_pop("R4 random");
      if ($urandom % 10 == 0) begin
        @(negedge clk) rx_en = 1'b0;
        m_ovf = 1'b0;
        @(negedge clk) rx_en = 1'b1;
        check_head("R8 random");
        wait_tick();
      end
    end
    while (m_cnt > 0) do_pop("R4 drain");
    check_head("R5 drained");
    finish_up();
  end
endmodule